// File: doc/BRIEF.md
# Banked Display RAM Write Controller

This block is the host-facing write side of an eight-digit multiplexed LED display controller. A host drives an 8-bit data bus, a select line `mode_ctl` and a write strobe that is already synchronised to the system clock. It holds the control settings and the per-digit display storage. It presents the stored data for every digit, together with a per-digit decode flag, the global decode scheme, a blank signal and a shutdown signal, to the scan and segment logic that follows.

A write with `mode_ctl` high loads a control word. That word sets the decode scheme, decode or raw format, shutdown, the active bank and a digit address. It also sets how the data writes that follow are steered. Bit 7 of the word picks one of two ways. When the bit is set, the display is blanked and the next eight data writes fill digits 1 to 8 in order. When the bit is clear, each data write lands in the one digit that the word addresses. In decoded format every digit has two 4-bit banks and one decimal point that both banks share. In raw format the full byte is stored.

Top module: `dispwr_ctrl`

## Requirements
- R1: After reset every digit output `dig_data` is 0x00, `dig_dec` is 0, `blank` is 0, `shutdown` is 0 and `scheme_hex` is 1. The reset control word is 0x70: shutdown inactive, decoded format, hex scheme, bank A, address 0, single-digit mode.
- R2: A control write (`wr_stb` with `mode_ctl` high) whose bit 7 is 0 changes only the control settings. Stored digit values and decode flags stay as they were.
- R3: A control write with bit 7 set drives `blank` to 1 in the cycle after the strobe.
- R4: In a burst the eight data writes (`mode_ctl` low) go to digit 0 (lowest byte of `dig_data`) through digit 7 in that order. `blank` returns to 0 in the cycle after the eighth write.
- R5: After a burst completes, further data writes change no digit until a new control word is written.
- R6: Every digit written in a burst takes the decode flag given by bit 5 of the control word that started the burst.
- R7: In decoded format (bit 5 = 1), a data write stores data bits 3:0 into the bank picked by control bit 3 (0 = A, 1 = B). The other bank is kept. Every decoded digit shows the bank named by the current control bit 3.
- R8: A decoded data write stores data bit 7 as that digit's decimal point, and the point is shared by both banks. A decoded digit is output as {point, 3'b000, nibble}.
- R9: In raw format (bit 5 = 0), a data write stores all 8 data bits and the digit outputs them unchanged, with its `dig_dec` bit at 0.
- R10: In single-digit mode, control bits 2:0 give the digit address. A data write changes only that digit.
- R11: Each digit's `dig_dec` bit takes control bit 5 at the time that digit was written. `scheme_hex` follows control bit 4 of the latest control word (1 = hex, 0 = code B).
- R12: `shutdown` is the inverse of control bit 6 of the latest control word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | Single-cycle write strobe |
| mode_ctl | input | 1 | 1 = control word, 0 = display data |
| din | input | 8 | Host data bus |
| dig_data | output | 64 | Per-digit data, digit i in bits 8i+7:8i |
| dig_dec | output | 8 | Per-digit decoded flag |
| scheme_hex | output | 1 | 1 = hex scheme, 0 = code B |
| blank | output | 1 | Display blanked during a burst |
| shutdown | output | 1 | Display shut down |

## Verification
Single-digit writes are made in decoded and raw format. Comparing the targeted digit with its neighbours shows whether addressing reaches only one location and whether the byte goes through whole or reduced to a nibble. The same digit is written in bank A and then bank B with different decimal-point values, and the bank is then switched back and forth with control-only words. This separates banked nibble storage from the shared point. Two bursts, one decoded and one raw, each carry an ascending pattern. The pattern exposes digit ordering, the blank window and the format flag per digit, and a write after the burst shows whether the lock-out holds.

// File: rtl/dispwr_pkg.sv
// Shared constants for the display write controller: control word bit
// positions, reset control value and sequencer state encoding.
package dispwr_pkg;
    localparam int CB_DATA_COMING = 7;
    localparam int CB_RUN_N       = 6;
    localparam int CB_DECODE      = 5;
    localparam int CB_HEX         = 4;
    localparam int CB_BANK        = 3;
    localparam logic [6:0] CTRL_RESET = 7'h70;

    typedef enum logic [1:0] {
        ST_SINGLE = 2'd0,
        ST_BURST  = 2'd1,
        ST_DONE   = 2'd2
    } seq_state_t;
endpackage

// File: rtl/dispwr_seq.sv
// Control register and write sequencer. It latches control words and turns
// each data write into a RAM write enable and digit address. In single mode
// the address comes from the control word. In a burst a counter supplies it,
// and once all digits are filled further writes are dropped.
// Assumes wr_stb is one clock wide per host write.
module dispwr_seq
    import dispwr_pkg::*;
#(
    parameter int NUM_DIGITS = 8,
    parameter int ADDR_W     = $clog2(NUM_DIGITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              mode_ctl,
    input  logic [7:0]        din,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              fmt_dec,
    output logic              bank_sel,
    output logic              scheme_hex,
    output logic              shutdown,
    output logic              blank
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_DIGITS - 1);

    logic [6:0]        ctrl_q;
    seq_state_t        state_q;
    logic [ADDR_W-1:0] cnt_q;

    wire ctl_wr  = wr_stb && mode_ctl;
    wire data_wr = wr_stb && !mode_ctl;

    // Control register: latch settings on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= CTRL_RESET;
        else if (ctl_wr) ctrl_q <= din[6:0];
    end

    // Sequencer: pick burst or single mode, step the burst counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SINGLE;
            cnt_q   <= '0;
        end else if (ctl_wr) begin
            state_q <= din[CB_DATA_COMING] ? ST_BURST : ST_SINGLE;
            cnt_q   <= '0;
        end else if (data_wr && state_q == ST_BURST) begin
            if (cnt_q == LAST_ADDR) state_q <= ST_DONE;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Write steering towards the digit storage.
    always_comb begin
        ram_we   = data_wr && (state_q != ST_DONE);
        ram_addr = (state_q == ST_BURST) ? cnt_q : ctrl_q[ADDR_W-1:0];
    end

    assign fmt_dec    = ctrl_q[CB_DECODE];
    assign bank_sel   = ctrl_q[CB_BANK];
    assign scheme_hex = ctrl_q[CB_HEX];
    assign shutdown   = !ctrl_q[CB_RUN_N];
    assign blank      = (state_q == ST_BURST);
endmodule

// File: rtl/dispwr_store.sv
// Per-digit display storage: two nibble banks, a shared decimal point, a
// raw byte and a decode flag for each digit. The output mux presents either
// the selected bank with its point or the raw byte, according to the flag.
module dispwr_store #(
    parameter int NUM_DIGITS = 8,
    parameter int ADDR_W     = $clog2(NUM_DIGITS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [7:0]              wdata,
    input  logic                    wdec,
    input  logic                    wbank,
    input  logic                    show_bank,
    output logic [NUM_DIGITS*8-1:0] dig_data,
    output logic [NUM_DIGITS-1:0]   dig_dec
);
    for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
        logic [3:0] nib_a, nib_b;
        logic       pt;
        logic [7:0] raw;
        logic       decf;
        wire        hit = we && (addr == ADDR_W'(d));

        // Digit cell: store the write into this digit when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                nib_a <= '0;
                nib_b <= '0;
                pt    <= 1'b0;
                raw   <= '0;
                decf  <= 1'b0;
            end else if (hit) begin
                decf <= wdec;
                if (wdec) begin
                    pt <= wdata[7];
                    if (wbank) nib_b <= wdata[3:0];
                    else       nib_a <= wdata[3:0];
                end else begin
                    raw <= wdata;
                end
            end
        end

        // Output mux: decoded digit shows point and chosen bank nibble.
        always_comb begin
            if (decf) dig_data[d*8 +: 8] = {pt, 3'b000, show_bank ? nib_b : nib_a};
            else      dig_data[d*8 +: 8] = raw;
        end
        assign dig_dec[d] = decf;
    end
endmodule

// File: rtl/dispwr_ctrl.sv
// Top of the display write controller: connects the control/sequencer to
// the digit storage. Inputs are synchronous; wr_stb is a one-cycle pulse.
module dispwr_ctrl #(
    parameter int NUM_DIGITS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_stb,
    input  logic                    mode_ctl,
    input  logic [7:0]              din,
    output logic [NUM_DIGITS*8-1:0] dig_data,
    output logic [NUM_DIGITS-1:0]   dig_dec,
    output logic                    scheme_hex,
    output logic                    blank,
    output logic                    shutdown
);
    localparam int ADDR_W = $clog2(NUM_DIGITS);

    logic              ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic              fmt_dec;
    logic              bank_sel;

    dispwr_seq #(.NUM_DIGITS(NUM_DIGITS), .ADDR_W(ADDR_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .mode_ctl   (mode_ctl),
        .din        (din),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .fmt_dec    (fmt_dec),
        .bank_sel   (bank_sel),
        .scheme_hex (scheme_hex),
        .shutdown   (shutdown),
        .blank      (blank)
    );

    dispwr_store #(.NUM_DIGITS(NUM_DIGITS), .ADDR_W(ADDR_W)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (ram_we),
        .addr      (ram_addr),
        .wdata     (din),
        .wdec      (fmt_dec),
        .wbank     (bank_sel),
        .show_bank (bank_sel),
        .dig_data  (dig_data),
        .dig_dec   (dig_dec)
    );
endmodule

// File: rtl/dispwr_chk.sv
// Property checker for dispwr_ctrl, attached by bind. Observes ports only.
module dispwr_chk #(
    parameter int NUM_DIGITS = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_stb,
    input logic                    mode_ctl,
    input logic [7:0]              din,
    input logic [NUM_DIGITS*8-1:0] dig_data,
    input logic [NUM_DIGITS-1:0]   dig_dec,
    input logic                    scheme_hex,
    input logic                    blank,
    input logic                    shutdown
);
    // R3
    burst_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && mode_ctl && din[7]) |=> blank);

    // R4
    unblank_on_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blank) |-> $past(wr_stb && !mode_ctl));

    // R2
    ctrl_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && mode_ctl) |=> $stable(dig_dec));

    // R5
    idle_holds_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(dig_data));

    // R11
    scheme_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && mode_ctl) |=> (scheme_hex == $past(din[4])));

    // R12
    shutdown_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && mode_ctl) |=> (shutdown == !$past(din[6])));
endmodule

bind dispwr_ctrl dispwr_chk #(.NUM_DIGITS(NUM_DIGITS)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .mode_ctl   (mode_ctl),
    .din        (din),
    .dig_data   (dig_data),
    .dig_dec    (dig_dec),
    .scheme_hex (scheme_hex),
    .blank      (blank),
    .shutdown   (shutdown)
);

// File: tb/test_dispwr_ctrl.sv
// Directed bench for dispwr_ctrl: one task per scenario.
module test_dispwr_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic        mode_ctl = 1'b0;
    logic [7:0]  din = 8'h00;
    logic [63:0] dig_data;
    logic [7:0]  dig_dec;
    logic        scheme_hex, blank, shutdown;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dispwr_ctrl i_dispwr_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .mode_ctl(mode_ctl),
        .din(din), .dig_data(dig_data), .dig_dec(dig_dec),
        .scheme_hex(scheme_hex), .blank(blank), .shutdown(shutdown)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One host write; returns at the negedge after the capturing edge.
    task automatic host_wr(input logic m, input logic [7:0] d);
        @(negedge clk);
        mode_ctl = m; din = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    function automatic logic [7:0] dig(input int i);
        return dig_data[i*8 +: 8];
    endfunction

    task automatic t_reset();
        chk("R1 data", dig_data, 64'h0);
        chk("R1 dec", {56'h0, dig_dec}, 64'h0);
        chk("R1 blank", {63'h0, blank}, 64'h0);
        chk("R1 shutdown", {63'h0, shutdown}, 64'h0);
        chk("R1 scheme", {63'h0, scheme_hex}, 64'h1);
    endtask

    task automatic t_single();
        host_wr(1'b1, 8'h72);
        host_wr(1'b0, 8'h85);
        chk("R10 digit2", {56'h0, dig(2)}, 64'h85);
        chk("R10 others", dig_data & ~(64'hFF << 16), 64'h0);
        chk("R11 flag", {56'h0, dig_dec}, 64'h04);
    endtask

    task automatic t_banks();
        host_wr(1'b1, 8'h7A);
        host_wr(1'b0, 8'h09);
        chk("R7 bank B shown", {56'h0, dig(2)}, 64'h09);
        host_wr(1'b1, 8'h72);
        chk("R8 shared point", {56'h0, dig(2)}, 64'h05);
        chk("R2 flags kept", {56'h0, dig_dec}, 64'h04);
        host_wr(1'b1, 8'h7A);
        host_wr(1'b0, 8'h83);
        host_wr(1'b1, 8'h72);
        chk("R8 point both banks", {56'h0, dig(2)}, 64'h85);
    endtask

    task automatic t_raw();
        host_wr(1'b1, 8'h54);
        host_wr(1'b0, 8'hA7);
        chk("R9 raw byte", {56'h0, dig(4)}, 64'hA7);
        chk("R11 raw flag", {56'h0, dig_dec}, 64'h04);
        chk("R7 decoded digit kept", {56'h0, dig(2)}, 64'h85);
    endtask

    task automatic t_scheme();
        host_wr(1'b1, 8'h62);
        chk("R11 code B", {63'h0, scheme_hex}, 64'h0);
        chk("R2 data kept", {48'h0, dig(4), dig(2), 8'h00, 8'h00}, {48'h0, 8'hA7, 8'h85, 16'h0});
        host_wr(1'b1, 8'h22);
        chk("R12 shutdown", {63'h0, shutdown}, 64'h1);
        host_wr(1'b1, 8'h72);
        chk("R12 run", {63'h0, shutdown}, 64'h0);
    endtask

    task automatic t_burst_dec();
        host_wr(1'b1, 8'hF0);
        chk("R3 blank", {63'h0, blank}, 64'h1);
        for (int i = 0; i < 7; i++) host_wr(1'b0, 8'(i + 8'h10));
        chk("R4 blank held", {63'h0, blank}, 64'h1);
        host_wr(1'b0, 8'h97);
        chk("R4 unblank", {63'h0, blank}, 64'h0);
        chk("R4 order", dig_data, 64'h87_06_05_04_03_02_01_00);
        chk("R6 all decoded", {56'h0, dig_dec}, 64'hFF);
        host_wr(1'b0, 8'h0F);
        chk("R5 ignored", dig_data, 64'h87_06_05_04_03_02_01_00);
    endtask

    task automatic t_burst_raw();
        host_wr(1'b1, 8'hD0);
        for (int i = 0; i < 8; i++) host_wr(1'b0, 8'(8'hA0 + i));
        chk("R6 raw flags", {56'h0, dig_dec}, 64'h00);
        chk("R9 raw burst", dig_data, 64'hA7_A6_A5_A4_A3_A2_A1_A0);
        host_wr(1'b1, 8'h73);
        host_wr(1'b0, 8'h0C);
        chk("R10 single after burst", dig_data, 64'hA7_A6_A5_A4_0C_A2_A1_A0);
    endtask

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_banks();
        t_raw();
        t_scheme();
        t_burst_dec();
        t_burst_raw();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule